// File: doc/BRIEF.md
# ADC Conversion Sequence Status Tracker

This block keeps the status byte of a multi-channel ADC sequencer. It holds three sticky flags and a small conversion counter. The flags are: a sequence-done flag, a trigger-overrun flag and a result-overrun flag. The counter names the result slot that the conversion in flight will fill. The block does no conversion itself. It watches the sequencer's events (a result written, a sequence finished, an external trigger edge) together with the per-slot conversion-complete flags. It also watches a few register-bus strobes: a write that starts a sequence, a write to any configuration or compare register (which aborts the running sequence), a write to the status byte itself, and a read of a result register. From these it updates the status byte on every clock.

Each flag has its own set of clear sources. The counter is cleared or kept at the end of a sequence, depending on whether the result slots are used as a circular queue. Software reads the status byte as one 8-bit value.

Top module: `adc_seq_status`

## Requirements
- R1: After reset the status byte reads 0x00. Bit 6 always reads 0. The byte is packed as: bit 7 done flag, bit 5 trigger overrun, bit 4 result overrun, bits 3..0 counter.
- R2: The done flag (bit 7) sets on the cycle after `seqDone` is high. It sets again on every later completion. A `startWrite` or `cfgWrite` in the same cycle suppresses the set.
- R3: The done flag clears in three cases: a status write with data bit 7 = 1, a `startWrite`, or a `resultRead` while `fastClear` = 1. A same-cycle set beats a status write or a fast clear.
- R4: A sequence is in progress from a `startWrite` until `seqDone` or `cfgWrite`. A start wins if both arrive in one cycle. The trigger-overrun flag (bit 5) sets when `trigEdge` arrives while a sequence is in progress and `levelTrig` = 0. It does not set when the tracker is idle or when `levelTrig` = 1.
- R5: The result-overrun flag (bit 4) sets when `resWrite` arrives while `ccfFlags[counter]` is 1.
- R6: Bits 5 and 4 clear on a status write with a 1 in their own bit position, on `cfgWrite`, or on `startWrite`. A start or abort beats a same-cycle set. A same-cycle set beats the status write.
- R7: The counter advances by one on each `resWrite`. After the value `seqLast` it wraps to 0.
- R8: With `fifoMode` = 0 the counter returns to 0 when `seqDone` arrives. With `fifoMode` = 1 it keeps counting across sequences, and a same-cycle `resWrite` still advances it.
- R9: `startWrite` or `cfgWrite` clears the counter in both modes.
- R10: Status writes never change the counter bits. Writing 0 to a flag bit leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Write to any configuration or compare register (aborts the sequence) |
| startWrite | input | 1 | Write to the sequence-start register |
| statWrite | input | 1 | Write to the status byte |
| statWrData | input | 8 | Data of the status write (ones clear flags) |
| resultRead | input | 1 | Read of any result register |
| fastClear | input | 1 | Result reads clear the done flag |
| fifoMode | input | 1 | Counter kept across sequences |
| levelTrig | input | 1 | Trigger is level sensitive (no overrun detection) |
| seqLast | input | 4 | Last slot index before the counter wraps |
| seqDone | input | 1 | Sequencer finished a sequence |
| resWrite | input | 1 | Sequencer wrote a result slot |
| trigEdge | input | 1 | Active external trigger edge seen |
| ccfFlags | input | 16 | Per-slot conversion-complete flags |
| statusReg | output | 8 | Packed status byte |

## Verification
A wrong in-progress bit inside the tracker shows up only on the next trigger edge, as a missing or spurious bit 5. The bench therefore fires trigger edges both while idle and while busy. A counter that is off by one shows up on the very next cycle in bits 3..0. It also shifts which conversion-complete flag is consulted, so bit 4 goes wrong on a later result write. Priority mistakes between set and clear sources show up one cycle after the colliding events. The directed cases and the random mix both produce such collisions, and every cycle is compared with a bench model.

// File: rtl/adc_seq_status_pkg.sv
package adc_seq_status_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrAll;   // start or abort seen
    logic setScf;
    logic clrScf;
    logic setEtorf;
    logic clrEtorf;
    logic setFifor;
    logic clrFifor;
    logic cntZero;  // counter forced to zero
    logic cntInc;   // counter advance request
  } ctlStrb_t;

  // flag positions counted down from the top of the status byte
  localparam int SCF_OFS   = 1;
  localparam int RSV_OFS   = 2;
  localparam int ETORF_OFS = 3;
  localparam int FIFOR_OFS = 4;

endpackage

// File: rtl/adc_seq_status_ctrl.sv
module adc_seq_status_ctrl
  import adc_seq_status_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int SLOTS = 2 ** CNT_W,
  localparam int STAT_W = CNT_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic              startWrite,
  input  logic              statWrite,
  input  logic [STAT_W-1:0] statWrData,
  input  logic              resultRead,
  input  logic              fastClear,
  input  logic              fifoMode,
  input  logic              levelTrig,
  input  logic              seqDone,
  input  logic              resWrite,
  input  logic              trigEdge,
  input  logic [SLOTS-1:0]  ccfFlags,
  input  logic [CNT_W-1:0]  curCnt,
  output ctlStrb_t          strb
);

  logic active;
  logic clrAny;
  logic [STAT_W-1:0] w1cMask;

  assign clrAny  = startWrite | cfgWrite;
  assign w1cMask = statWrite ? statWrData : '0;

  // sequence-in-progress tracking; start beats done/abort
  always_ff @(posedge clk) begin
    if (!rstN)               active <= 1'b0;
    else if (startWrite)     active <= 1'b1;
    else if (cfgWrite || seqDone) active <= 1'b0;
  end

  always_comb begin
    strb          = '0;
    strb.clrAll   = clrAny;
    strb.setScf   = seqDone & ~clrAny;
    strb.clrScf   = startWrite | w1cMask[STAT_W-SCF_OFS] | (fastClear & resultRead);
    strb.setEtorf = trigEdge & ~levelTrig & active & ~clrAny;
    strb.clrEtorf = clrAny | w1cMask[STAT_W-ETORF_OFS];
    strb.setFifor = resWrite & ccfFlags[curCnt] & ~clrAny;
    strb.clrFifor = clrAny | w1cMask[STAT_W-FIFOR_OFS];
    strb.cntZero  = clrAny | (seqDone & ~fifoMode);
    strb.cntInc   = resWrite;
  end

  // R4: completion without a new start ends the sequence
  assert_done_ends_seq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && !startWrite) |=> !active);

  // R4: abort without a new start ends the sequence
  assert_abort_ends_seq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !startWrite) |=> !active);

  // R4: overrun set only for edges while busy
  assert_edge_needs_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (trigEdge && !active) |-> !strb.setEtorf);

endmodule

// File: rtl/adc_seq_status_dp.sv
module adc_seq_status_dp
  import adc_seq_status_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int STAT_W = CNT_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [CNT_W-1:0]  seqLast,
  output logic [CNT_W-1:0]  curCnt,
  output logic [STAT_W-1:0] statusReg
);

  logic scf, etorf, fifor;
  logic [CNT_W-1:0] cnt;

  // set beats clear for each flag; start/abort already masked the sets
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scf   <= 1'b0;
      etorf <= 1'b0;
      fifor <= 1'b0;
    end else begin
      if (strb.setScf)        scf <= 1'b1;
      else if (strb.clrScf)   scf <= 1'b0;
      if (strb.setEtorf)      etorf <= 1'b1;
      else if (strb.clrEtorf) etorf <= 1'b0;
      if (strb.setFifor)      fifor <= 1'b1;
      else if (strb.clrFifor) fifor <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (strb.cntZero)   cnt <= '0;
    else if (strb.cntInc)    cnt <= (cnt == seqLast) ? '0 : cnt + 1'b1;
  end

  assign curCnt    = cnt;
  assign statusReg = {scf, 1'b0, etorf, fifor, cnt};

  // R9: forced zero lands on the next cycle
  assert_cnt_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntZero |=> (curCnt == '0));

  // R7: wrap after the last slot
  assert_cnt_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntInc && !strb.cntZero && cnt == seqLast) |=> (curCnt == '0));

  // R7: plain advance
  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntInc && !strb.cntZero && cnt != seqLast) |=> (curCnt == CNT_W'($past(cnt) + 1'b1)));

  // R2: completion sets the done flag
  assert_scf_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setScf |=> statusReg[STAT_W-SCF_OFS]);

  // R6: start/abort leaves both overrun flags low
  assert_ovr_cleared_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (!statusReg[STAT_W-ETORF_OFS] && !statusReg[STAT_W-FIFOR_OFS]));

endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
  import adc_seq_status_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int SLOTS = 2 ** CNT_W,
  localparam int STAT_W = CNT_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic              startWrite,
  input  logic              statWrite,
  input  logic [STAT_W-1:0] statWrData,
  input  logic              resultRead,
  input  logic              fastClear,
  input  logic              fifoMode,
  input  logic              levelTrig,
  input  logic [CNT_W-1:0]  seqLast,
  input  logic              seqDone,
  input  logic              resWrite,
  input  logic              trigEdge,
  input  logic [SLOTS-1:0]  ccfFlags,
  output logic [STAT_W-1:0] statusReg
);

  ctlStrb_t strb;
  logic [CNT_W-1:0] curCnt;

  adc_seq_status_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrite   (cfgWrite),
    .startWrite (startWrite),
    .statWrite  (statWrite),
    .statWrData (statWrData),
    .resultRead (resultRead),
    .fastClear  (fastClear),
    .fifoMode   (fifoMode),
    .levelTrig  (levelTrig),
    .seqDone    (seqDone),
    .resWrite   (resWrite),
    .trigEdge   (trigEdge),
    .ccfFlags   (ccfFlags),
    .curCnt     (curCnt),
    .strb       (strb)
  );

  adc_seq_status_dp #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .seqLast   (seqLast),
    .curCnt    (curCnt),
    .statusReg (statusReg)
  );

  // R10: a status write alone leaves the counter bits alone
  assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && !resWrite && !startWrite && !cfgWrite && !seqDone)
      |=> $stable(statusReg[CNT_W-1:0]));

  // R1: reserved bit stays low
  assert_reserved_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[STAT_W-2] == 1'b0);

endmodule

// File: tb/tb_adc_seq_status.sv
module tb_adc_seq_status;

  localparam int CW = 4;
  localparam int SL = 16;

  logic clk = 1'b0;
  logic rstN;
  logic cfgWrite, startWrite, statWrite, resultRead, fastClear;
  logic fifoMode, levelTrig, seqDone, resWrite, trigEdge;
  logic [7:0] statWrData;
  logic [CW-1:0] seqLast;
  logic [SL-1:0] ccfFlags;
  logic [7:0] statusReg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_seq_status dut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .startWrite(startWrite),
    .statWrite(statWrite), .statWrData(statWrData), .resultRead(resultRead),
    .fastClear(fastClear), .fifoMode(fifoMode), .levelTrig(levelTrig),
    .seqLast(seqLast), .seqDone(seqDone), .resWrite(resWrite),
    .trigEdge(trigEdge), .ccfFlags(ccfFlags), .statusReg(statusReg)
  );

  // bench model built from the requirements
  logic mScf, mEt, mFo, mAct;
  logic [CW-1:0] mCnt;

  function automatic logic [7:0] modelByte();
    return {mScf, 1'b0, mEt, mFo, mCnt};
  endfunction

  always @(posedge clk) begin
    logic clr;
    logic [7:0] w;
    if (!rstN) begin
      mScf = 0; mEt = 0; mFo = 0; mAct = 0; mCnt = '0;
    end else begin
      clr = startWrite | cfgWrite;
      w = statWrite ? statWrData : 8'h00;
      if (seqDone && !clr) mScf = 1;                                   // R2
      else if (startWrite || w[7] || (fastClear && resultRead)) mScf = 0; // R3
      if (trigEdge && !levelTrig && mAct && !clr) mEt = 1;             // R4
      else if (clr || w[5]) mEt = 0;                                   // R6
      if (resWrite && ccfFlags[mCnt] && !clr) mFo = 1;                 // R5
      else if (clr || w[4]) mFo = 0;
      if (clr) mCnt = '0;                                              // R9
      else if (seqDone && !fifoMode) mCnt = '0;                        // R8
      else if (resWrite) mCnt = (mCnt == seqLast) ? '0 : mCnt + 1'b1;  // R7
      if (startWrite) mAct = 1;
      else if (cfgWrite || seqDone) mAct = 0;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: status actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clearIn();
    cfgWrite = 0; startWrite = 0; statWrite = 0; statWrData = 8'h00;
    resultRead = 0; seqDone = 0; resWrite = 0; trigEdge = 0;
  endtask

  // apply current inputs for one edge, then compare against model and constant
  task automatic tick(input string tag, input logic [7:0] exp);
    @(posedge clk);
    @(negedge clk);
    check(tag, statusReg, exp);
    check({tag, " model"}, statusReg, modelByte());
    clearIn();
  endtask

  function automatic string fieldTag(input logic [7:0] a, input logic [7:0] e);
    if (a[7] !== e[7]) return "R2 R3 done flag";
    if (a[6] !== e[6]) return "R1 reserved";
    if (a[5] !== e[5]) return "R4 R6 trigger overrun";
    if (a[4] !== e[4]) return "R5 R6 result overrun";
    return "R7 R8 R9 counter";
  endfunction

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'h5A17);
    clearIn();
    fastClear = 0; fifoMode = 0; levelTrig = 0; seqLast = 4'd3; ccfFlags = '0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    check("R1 reset", statusReg, 8'h00);

    startWrite = 1;             tick("R9 start", 8'h00);
    resWrite = 1;               tick("R7 step", 8'h01);
    resWrite = 1;               tick("R7 step", 8'h02);
    trigEdge = 1;               tick("R4 busy edge", 8'h22);
    ccfFlags = '1; resWrite = 1; tick("R5 overwrite", 8'h33);
    resWrite = 1;               tick("R7 wrap", 8'h30);
    ccfFlags = '0; seqDone = 1; tick("R2 R8 done", 8'hB0);
    trigEdge = 1;               tick("R4 idle edge", 8'hB0);
    statWrite = 1; statWrData = 8'h4F; tick("R10 write zeros", 8'hB0);
    statWrite = 1; statWrData = 8'h20; tick("R6 w1c", 8'h90);
    fastClear = 1; resultRead = 1; tick("R3 fast clear", 8'h10);
    fastClear = 0; cfgWrite = 1; tick("R6 abort", 8'h00);

    fifoMode = 1; startWrite = 1; tick("R9 start fifo", 8'h00);
    resWrite = 1;               tick("R7 step", 8'h01);
    resWrite = 1;               tick("R7 step", 8'h02);
    levelTrig = 1; trigEdge = 1; tick("R4 level mode", 8'h02);
    levelTrig = 0;
    seqDone = 1;                tick("R8 fifo keeps", 8'h82);
    resWrite = 1; seqDone = 1;  tick("R8 fifo done step", 8'h83);
    startWrite = 1;             tick("R9 R3 restart", 8'h00);
    resWrite = 1;               tick("R7 step", 8'h01);
    trigEdge = 1; cfgWrite = 1; tick("R9 R6 abort beats edge", 8'h00);
    statWrite = 1; statWrData = 8'h80; seqDone = 1; tick("R3 set wins", 8'h80);
    seqDone = 1; startWrite = 1; tick("R2 start suppresses", 8'h00);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] e;
      if ($urandom_range(0, 63) == 0) fifoMode  = $urandom_range(0, 1);
      if ($urandom_range(0, 63) == 0) levelTrig = $urandom_range(0, 1);
      if ($urandom_range(0, 63) == 0) seqLast   = CW'($urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) fastClear = $urandom_range(0, 1);
      ccfFlags   = SL'($urandom);
      cfgWrite   = ($urandom_range(0, 19) == 0);
      startWrite = ($urandom_range(0, 15) == 0);
      seqDone    = ($urandom_range(0, 9) == 0);
      resWrite   = ($urandom_range(0, 2) == 0);
      trigEdge   = ($urandom_range(0, 3) == 0);
      resultRead = ($urandom_range(0, 3) == 0);
      statWrite  = ($urandom_range(0, 7) == 0);
      statWrData = 8'($urandom);
      @(posedge clk);
      @(negedge clk);
      e = modelByte();
      check(fieldTag(statusReg, e), statusReg, e);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule